// File: doc/BRIEF.md
# Scan-List Acquisition Sequencer

This block drives a multiplexed analog-to-digital converter from a list of channel entries. The host programs it over a small word-addressed bus. Each entry is four 16-bit control words. The host pushes every word into the scan-list port as two byte writes, low byte first. When the sequencer runs, it moves words from the scan-list FIFO into a four-word configuration pipe. The assembled entry is presented to the converter as a 64-bit configuration vector.

A programmable pacer produces conversion ticks. A tick starts a conversion only when the pipe holds a complete entry and no conversion is outstanding. The converter answers with a done pulse and a data word. That word enters a results FIFO, and the host pops it by reading the results register. When a converted entry carries the suspend mark, scanning halts. Two sticky flags record overruns:

- a pacer tick that arrives while a conversion is still in flight;
- a result that arrives while the results FIFO is full.

The host drives all commands through one control register, each with its own code. The register map is: word address 0 is control (write) and status (read), 1 is the scan-list port, 2 and 3 are the low and high halves of the pacer divider, and 4 is the results register.

Top module: `acq_scan_seq`

## Requirements
- R1: A scan-list word is assembled from two writes to address 1, low byte first, each taken from bus bits 7:0. The word enters the scan-list FIFO only on the second write. Status bit 5 reads 1 while that FIFO is empty.
- R2: Control code 0x0011 starts moving scan-list words into the configuration pipe, one per cycle, and 0x0010 stops it. After four words the pipe is full, shown by status bit 4. While full, the pipe holds its contents.
- R3: A control write whose bits 15:3 are zero performs resets, which may be combined. Bit 2 clears the scan-list FIFO and the pending low byte. Bit 1 clears the results FIFO and both overrun flags. Bit 0 clears the configuration pipe.
- R4: Control code 0x0031 enables the pacer and 0x0030 disables it. With divider value D, written as low half at address 2 and high half at address 3, ticks come every D+1 cycles. A conversion request (adc_req high) starts only on a tick with a full pipe.
- R5: On each conversion done, adc_data is pushed to the results FIFO. A read at address 4 returns the oldest word and pops it. Status bit 1 means the FIFO is non-empty and bit 0 means it holds more than one word.
- R6: Bit 2 of an entry's second word marks it as last. After converting such an entry the sequencer stops, and status bit 3 (scanning: running or converting) drops. Entries without the mark are followed by the next entry.
- R7: A result arriving while the results FIFO is full, with no pop in the same cycle, is dropped and sets status bit 2. A result arriving together with a pop is accepted.
- R8: A pacer tick while a conversion is outstanding sets status bit 8.
- R9: After reset the status reads 0x0020, adc_req is low, and both the pacer and the sequencer are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops results at address 4) |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| adc_req | output | 1 | Conversion request, held until done |
| adc_cfg | output | 64 | The four words of the current entry, word 0 in bits 15:0 |
| adc_done | input | 1 | Conversion finished, one-cycle pulse |
| adc_data | input | 16 | Conversion result, valid with adc_done |

## Verification
The converter's completion, which pushes into the results FIFO, and the host's pop of that FIFO can land on the same clock edge. This matters most when the FIFO is already full. The bench provokes this by having its converter stub raise the read strobe at address 4 in the same cycle as the fifth done pulse, with four results already queued. It then judges that the overrun flag stayed clear and that the queue holds entries two to five in order.

// File: rtl/acq_scan_pkg.sv
package acq_scan_pkg;

    localparam int BUS_W       = 16;
    localparam int ENTRY_WORDS = 4;
    localparam int SUSPEND_BIT = 2;

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_SCAN   = 3'd1,
        A_DIVLO  = 3'd2,
        A_DIVHI  = 3'd3,
        A_RESULT = 3'd4
    } reg_addr_e;

    localparam logic [BUS_W-1:0] CMD_RUN      = 16'h0011;
    localparam logic [BUS_W-1:0] CMD_HALT     = 16'h0010;
    localparam logic [BUS_W-1:0] CMD_PACE_ON  = 16'h0031;
    localparam logic [BUS_W-1:0] CMD_PACE_OFF = 16'h0030;

    typedef struct packed {
        logic [6:0] rsv_hi;
        logic       pacer_ovr;
        logic [1:0] rsv_mid;
        logic       scan_empty;
        logic       pipe_full;
        logic       scanning;
        logic       res_ovr;
        logic       res_has;
        logic       res_multi;
    } status_t;

    typedef struct packed {
        logic clr_scan;
        logic clr_res;
        logic clr_pipe;
        logic run_on;
        logic run_off;
        logic pace_on;
        logic pace_off;
    } ctl_cmd_t;

    function automatic ctl_cmd_t decode_ctl(input logic [BUS_W-1:0] v);
        ctl_cmd_t c;
        c = '0;
        if (v[BUS_W-1:3] == '0) begin
            c.clr_scan = v[2];
            c.clr_res  = v[1];
            c.clr_pipe = v[0];
        end else begin
            case (v)
                CMD_RUN:      c.run_on   = 1'b1;
                CMD_HALT:     c.run_off  = 1'b1;
                CMD_PACE_ON:  c.pace_on  = 1'b1;
                CMD_PACE_OFF: c.pace_off = 1'b1;
                default:      ;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/acq_fifo.sv
module acq_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic          do_pop, do_push;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    p_hold_count_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr && !push && !pop) |=> $stable(count));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (!clr && push && full && !pop) |=> full);

endmodule

// File: rtl/acq_pacer.sv
module acq_pacer #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst || !en)   cnt <= '0;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    p_tick_restart_r4: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0));

endmodule

// File: rtl/acq_cfg_pipe.sv
module acq_cfg_pipe
    import acq_scan_pkg::*;
#(
    parameter int W = 16,
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           load,
    input  logic [W-1:0]   din,
    input  logic           consume,
    output logic           full,
    output logic [N*W-1:0] words,
    output logic           suspend
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] idx;
    logic [W-1:0]  slot [N];
    logic          take;

    assign take = load && !full;

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                             slot[g] <= '0;
            else if (take && idx == IW'(g))      slot[g] <= din;
        end
        assign words[g*W +: W] = slot[g];
    end

    assign suspend = slot[1][SUSPEND_BIT];

    always_ff @(posedge clk) begin
        if (rst || clr || consume) begin
            idx  <= '0;
            full <= 1'b0;
        end else if (take) begin
            idx <= (idx == IW'(N - 1)) ? '0 : idx + 1'b1;
            if (idx == IW'(N - 1)) full <= 1'b1;
        end
    end

    p_full_after_load_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(load));

    p_hold_when_full_r2: assert property (@(posedge clk) disable iff (rst)
        (full && !clr && !consume) |=> $stable(words));

endmodule

// File: rtl/acq_scan_seq.sv
module acq_scan_seq
    import acq_scan_pkg::*;
#(
    parameter int SCAN_DEPTH = 32,
    parameter int RES_DEPTH  = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [2:0]                   bus_addr,
    input  logic [BUS_W-1:0]             bus_wdata,
    output logic [BUS_W-1:0]             bus_rdata,
    output logic                         adc_req,
    output logic [ENTRY_WORDS*BUS_W-1:0] adc_cfg,
    input  logic                         adc_done,
    input  logic [BUS_W-1:0]             adc_data
);
    localparam int DIV_W   = 2 * BUS_W;
    localparam int SCAN_CW = $clog2(SCAN_DEPTH + 1);
    localparam int RES_CW  = $clog2(RES_DEPTH + 1);

    ctl_cmd_t            cmd;
    status_t             st;
    logic                wr_ctl;
    logic                phase_q;
    logic [7:0]          lo_q;
    logic                run_q, pace_q, busy_q, last_q;
    logic                res_ovr_q, pac_ovr_q;
    logic [DIV_W-1:0]    div_q;

    logic                scan_push, scan_empty, scan_full;
    logic [BUS_W-1:0]    scan_dout;
    logic [SCAN_CW-1:0]  scan_count;
    logic                scan_unused;

    logic                pipe_load, pipe_full, pipe_suspend;
    logic                tick, conv_done;

    logic                res_pop, res_empty, res_full;
    logic [BUS_W-1:0]    res_dout;
    logic [RES_CW-1:0]   res_count;

    assign wr_ctl      = bus_wr && (bus_addr == A_CTRL);
    assign cmd         = wr_ctl ? decode_ctl(bus_wdata) : '0;
    assign scan_push   = bus_wr && (bus_addr == A_SCAN) && phase_q;
    assign pipe_load   = run_q && !pipe_full && !scan_empty;
    assign conv_done   = busy_q && adc_done;
    assign res_pop     = bus_rd && (bus_addr == A_RESULT);
    assign scan_unused = ^{scan_count, scan_full};

    acq_fifo #(.W(BUS_W), .DEPTH(SCAN_DEPTH)) u_scan_fifo (
        .clk(clk), .rst(rst), .clr(cmd.clr_scan),
        .push(scan_push), .din({bus_wdata[7:0], lo_q}),
        .pop(pipe_load), .dout(scan_dout), .count(scan_count),
        .full(scan_full), .empty(scan_empty));

    acq_cfg_pipe #(.W(BUS_W), .N(ENTRY_WORDS)) u_pipe (
        .clk(clk), .rst(rst), .clr(cmd.clr_pipe), .load(pipe_load),
        .din(scan_dout), .consume(conv_done), .full(pipe_full),
        .words(adc_cfg), .suspend(pipe_suspend));

    acq_pacer #(.DIV_W(DIV_W)) u_pacer (
        .clk(clk), .rst(rst), .en(pace_q), .div(div_q), .tick(tick));

    acq_fifo #(.W(BUS_W), .DEPTH(RES_DEPTH)) u_res_fifo (
        .clk(clk), .rst(rst), .clr(cmd.clr_res),
        .push(conv_done), .din(adc_data),
        .pop(res_pop), .dout(res_dout), .count(res_count),
        .full(res_full), .empty(res_empty));

    // Byte assembly of scan-list words
    always_ff @(posedge clk) begin
        if (rst || cmd.clr_scan) begin
            phase_q <= 1'b0;
            lo_q    <= '0;
        end else if (bus_wr && bus_addr == A_SCAN) begin
            if (!phase_q) lo_q <= bus_wdata[7:0];
            phase_q <= !phase_q;
        end
    end

    // Divider registers
    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else if (bus_wr && bus_addr == A_DIVLO) div_q[BUS_W-1:0]     <= bus_wdata;
        else if (bus_wr && bus_addr == A_DIVHI) div_q[DIV_W-1:BUS_W] <= bus_wdata;
    end

    // Run and pacer enables, conversion tracking, sticky flags
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= 1'b0;
            pace_q    <= 1'b0;
            busy_q    <= 1'b0;
            last_q    <= 1'b0;
            res_ovr_q <= 1'b0;
            pac_ovr_q <= 1'b0;
        end else begin
            if (conv_done && last_q) run_q <= 1'b0;
            if (cmd.run_on)          run_q <= 1'b1;
            if (cmd.run_off)         run_q <= 1'b0;
            if (cmd.pace_on)         pace_q <= 1'b1;
            if (cmd.pace_off)        pace_q <= 1'b0;

            if (conv_done) begin
                busy_q <= 1'b0;
            end else if (tick && !busy_q && pipe_full) begin
                busy_q <= 1'b1;
                last_q <= pipe_suspend;
            end

            if (cmd.clr_res) begin
                res_ovr_q <= 1'b0;
                pac_ovr_q <= 1'b0;
            end else begin
                if (conv_done && res_full && !res_pop) res_ovr_q <= 1'b1;
                if (tick && busy_q && !adc_done)       pac_ovr_q <= 1'b1;
            end
        end
    end

    always_comb begin
        st            = '0;
        st.res_multi  = (res_count > RES_CW'(1));
        st.res_has    = !res_empty;
        st.res_ovr    = res_ovr_q;
        st.scanning   = run_q || busy_q;
        st.pipe_full  = pipe_full;
        st.scan_empty = scan_empty;
        st.pacer_ovr  = pac_ovr_q;
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:   bus_rdata = st;
            A_DIVLO:  bus_rdata = div_q[BUS_W-1:0];
            A_DIVHI:  bus_rdata = div_q[DIV_W-1:BUS_W];
            A_RESULT: bus_rdata = res_empty ? '0 : res_dout;
            default:  bus_rdata = '0;
        endcase
    end

    assign adc_req = busy_q;

    p_req_start_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_req) |-> ($past(pipe_full) && $past(pace_q)));

    p_suspend_halt_r6: assert property (@(posedge clk) disable iff (rst)
        (conv_done && last_q && !cmd.run_on) |=> !st.scanning);

    p_pacer_ovr_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && adc_req && !adc_done && !cmd.clr_res) |=> st.pacer_ovr);

    p_res_ovr_r7: assert property (@(posedge clk) disable iff (rst)
        (conv_done && res_full && !res_pop && !cmd.clr_res) |=> st.res_ovr);

    p_reset_idle_r9: assert property (@(posedge clk)
        rst |=> (!adc_req && st.scan_empty && !st.scanning));

endmodule

// File: tb/test_acq_scan_seq.sv
module test_acq_scan_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        adc_req;
    logic [63:0] adc_cfg;
    logic        adc_done = 1'b0;
    logic [15:0] adc_data = 16'h0;

    int  n_chk = 0;
    int  n_fail = 0;
    int  cyc = 0;
    int  lat = 2;
    int  ndone = 0;
    int  nrise = 0;
    int  rise [4];
    bit  pop_on_done = 1'b0;
    bit  finished = 1'b0;

    localparam logic [31:0] VECS [4] = '{
        {16'h0000, 16'h5A5A},
        {16'hFFFF, 16'hA5A5},
        {16'h1234, 16'h486E},
        {16'h00C0, 16'h5A9A}
    };

    acq_scan_seq i_acq_scan_seq (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .adc_req(adc_req), .adc_cfg(adc_cfg),
        .adc_done(adc_done), .adc_data(adc_data));

    always #4 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
        end
    end

    // Converter stub: result = word 0 of the entry XOR 0x5A5A
    initial begin
        int  w;
        bit  prev;
        bit  popped;
        w = 0; prev = 1'b0; popped = 1'b0;
        forever begin
            @(negedge clk);
            if (adc_req && !prev && nrise < 4) begin
                rise[nrise] = cyc;
                nrise++;
            end
            prev = adc_req;
            if (adc_done) begin
                adc_done = 1'b0;
                w = 0;
                if (popped) begin
                    bus_rd = 1'b0;
                    popped = 1'b0;
                end
            end else if (adc_req) begin
                w++;
                if (w >= lat) begin
                    adc_done = 1'b1;
                    adc_data = adc_cfg[15:0] ^ 16'h5A5A;
                    if (pop_on_done && ndone == 4) begin
                        bus_addr = 3'd4;
                        bus_rd   = 1'b1;
                        popped   = 1'b1;
                    end
                    ndone++;
                end
            end
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_word(input logic [15:0] w);
        wr(3'd1, {8'h00, w[7:0]});
        wr(3'd1, {8'h00, w[15:8]});
    endtask

    task automatic put_entry(input logic [15:0] w0, input bit last);
        wr_word(w0);
        wr_word(last ? 16'h0004 : 16'h0000);
        wr_word(16'h0800);
        wr_word(16'hC001);
    endtask

    task automatic rd_status(output logic [15:0] s);
        @(negedge clk);
        bus_addr = 3'd0;
        #1 s = bus_rdata;
    endtask

    task automatic pop_result(output logic [15:0] v);
        @(negedge clk);
        bus_addr = 3'd4;
        #1 v = bus_rdata;
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_bits(input logic [15:0] mask, input logic [15:0] val, input int maxc);
        logic [15:0] s;
        for (int i = 0; i < maxc; i++) begin
            rd_status(s);
            if ((s & mask) == val) break;
        end
    endtask

    task automatic set_div(input logic [31:0] d);
        wr(3'd2, d[15:0]);
        wr(3'd3, d[31:16]);
    endtask

    task automatic clean();
        wr(3'd0, 16'h0030);
        wr(3'd0, 16'h0010);
        repeat (20) @(negedge clk);
        wr(3'd0, 16'h0007);
        lat = 2;
    endtask

    initial begin
        logic [15:0] s;
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        rd_status(s);
        check("R9 status after reset", s, 16'h0020);
        check("R9 adc_req after reset", {15'h0, adc_req}, 16'h0000);

        // R1: byte assembly
        wr(3'd1, 16'h0034);
        rd_status(s);
        check("R1 low byte alone leaves FIFO empty", s & 16'h0020, 16'h0020);
        wr(3'd1, 16'h0012);
        rd_status(s);
        check("R1 high byte completes word", s & 16'h0020, 16'h0000);
        wr(3'd0, 16'h0004);
        rd_status(s);
        check("R3 scan-list reset empties FIFO", s, 16'h0020);

        // R2: no loading while halted, then start
        put_entry(16'h0101, 1'b1);
        repeat (20) @(negedge clk);
        rd_status(s);
        check("R2 halted: pipe not full", s, 16'h0000);
        wr(3'd0, 16'h0011);
        repeat (8) @(negedge clk);
        rd_status(s);
        check("R2 running: pipe full, FIFO drained", s, 16'h0038);

        // R4: no conversion without pacer
        repeat (40) @(negedge clk);
        check("R4 no request without pacer", {15'h0, adc_req}, 16'h0000);
        rd_status(s);
        check("R4 no result without pacer", s & 16'h0003, 16'h0000);
        wr(3'd0, 16'h0001);
        rd_status(s);
        check("R3 pipe reset clears full", s & 16'h0010, 16'h0000);
        clean();

        // Vector table: single-shot acquisitions
        for (int k = 0; k < 4; k++) begin
            put_entry(VECS[k][31:16], 1'b1);
            set_div(32'd5);
            wr(3'd0, 16'h0011);
            wait_bits(16'h0010, 16'h0010, 50);
            rd_status(s);
            check("R2 pipe full before pacing", s & 16'h0010, 16'h0010);
            wr(3'd0, 16'h0031);
            wait_bits(16'h0002, 16'h0002, 100);
            rd_status(s);
            check("R6 scanning stopped after suspend entry", s, 16'h0022);
            pop_result(v);
            check("R5 result value", v, VECS[k][15:0]);
            clean();
        end

        // R3: partial byte discarded by scan-list reset
        wr(3'd1, 16'h0077);
        wr(3'd0, 16'h0004);
        put_entry(16'h4321, 1'b1);
        set_div(32'd5);
        wr(3'd0, 16'h0011);
        wr(3'd0, 16'h0031);
        wait_bits(16'h0002, 16'h0002, 100);
        pop_result(v);
        check("R3 byte phase reset", v, 16'h197B);
        clean();

        // R6 / R5: three entries, suspend on the last
        put_entry(16'h0101, 1'b0);
        put_entry(16'h0202, 1'b0);
        put_entry(16'h0303, 1'b1);
        set_div(32'd5);
        wr(3'd0, 16'h0011);
        wr(3'd0, 16'h0031);
        repeat (20) @(negedge clk);
        wait_bits(16'h0008, 16'h0000, 200);
        rd_status(s);
        check("R6 multi-entry scan halts at suspend", s, 16'h0023);
        pop_result(v); check("R5 order first", v, 16'h5B5B);
        pop_result(v); check("R5 order second", v, 16'h5858);
        pop_result(v); check("R5 order third", v, 16'h5959);
        rd_status(s);
        check("R5 empty after draining", s & 16'h0003, 16'h0000);
        clean();

        // R4: pacer period D+1
        nrise = 0;
        put_entry(16'h0A0A, 1'b0);
        put_entry(16'h0B0B, 1'b1);
        set_div(32'd20);
        wr(3'd0, 16'h0011);
        repeat (8) @(negedge clk);
        wr(3'd0, 16'h0031);
        repeat (80) @(negedge clk);
        check("R4 two requests seen", 16'(nrise), 16'd2);
        check("R4 tick spacing", 16'(rise[1] - rise[0]), 16'd21);
        clean();

        // R8: pacer overrun
        lat = 10;
        put_entry(16'h0C0C, 1'b1);
        set_div(32'd2);
        wr(3'd0, 16'h0011);
        repeat (8) @(negedge clk);
        wr(3'd0, 16'h0031);
        repeat (40) @(negedge clk);
        rd_status(s);
        check("R8 pacer overrun flagged", s, 16'h0122);
        wr(3'd0, 16'h0002);
        rd_status(s);
        check("R3 results reset clears flags", s, 16'h0020);
        clean();

        // R7: results overrun drops the sample
        for (int i = 1; i <= 6; i++) put_entry(16'h0B00 + 16'(i), i == 6);
        set_div(32'd5);
        wr(3'd0, 16'h0011);
        wr(3'd0, 16'h0031);
        repeat (200) @(negedge clk);
        rd_status(s);
        check("R7 results overrun flagged", s, 16'h0027);
        for (int i = 1; i <= 4; i++) begin
            pop_result(v);
            check("R7 kept oldest results", v, (16'h0B00 + 16'(i)) ^ 16'h5A5A);
        end
        clean();

        // R7: push and pop in the same cycle while full
        ndone = 0;
        pop_on_done = 1'b1;
        for (int i = 1; i <= 5; i++) put_entry(16'h0A00 + 16'(i), i == 5);
        set_div(32'd5);
        wr(3'd0, 16'h0011);
        wr(3'd0, 16'h0031);
        repeat (300) @(negedge clk);
        pop_on_done = 1'b0;
        rd_status(s);
        check("R7 simultaneous push/pop: no overrun", s, 16'h0023);
        for (int i = 2; i <= 5; i++) begin
            pop_result(v);
            check("R7 simultaneous push/pop contents", v, (16'h0A00 + 16'(i)) ^ 16'h5A5A);
        end
        clean();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule